// File: doc/BRIEF.md
# Multi-source Vectored Interrupt Controller

This block gathers twelve local interrupt sources into one prioritised request for a processor. Every source owns a control byte that holds a software-chosen 3-bit priority, an enable and a pending flag. The block drives the level of the strongest enabled, pending source onto a 3-bit output. A level of zero means that nothing is requested. One bit in a general control register gates every request at once.

Ten of the sources are hardware inputs. Each one latches pending on a rising edge and is cleared by software. The last two sources are software interrupts, and their pending flag is whatever software last wrote. When the processor acknowledges a level, the block answers one clock later. If the acknowledged level matches the current winner, the answer is a vector equal to a programmable base plus the winner's fixed index. Otherwise the answer is a spurious indication. The serial source can instead hand the vector duty to its own device.

The fixed source indices are: 0 power-fail, 1 bus error, 2 abort switch, 3 serial, 4 network, 5 disk, 6 DMA, 7 printer, 8 timer 1, 9 timer 2, 10 software 1, 11 software 2.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all control bytes read 0x00, the vector base (address 12) reads 0x40, the general control register (address 13) reads 0x00, `irq_level` is 0 and `ack_valid` is 0.
- R2: For a hardware source (indices 0 to 9), pending (bit 7 of its control byte) sets when its input is high at a clock edge and was low at the previous edge. Pending latches even while the source is disabled. An input held high does not set pending again after it is cleared. Writing a control byte with bit 7 set clears pending. If a rising edge and a clear arrive in the same cycle, the set wins.
- R3: For the software sources (10 and 11), pending takes the value of bit 7 on every write to the control byte, and the source input has no effect.
- R4: `irq_level` is the highest level field (bits 2:0) among sources that are pending, enabled (bit 3) and at a nonzero level. It is 0 when no such source exists or when the global enable (bit 4 of the general control register) is clear.
- R5: Among sources tied at the highest level, the one with the lowest index wins.
- R6: In the cycle after `iack_req` is sampled high, `ack_valid` is 1 for exactly one cycle. If `iack_level` equals the current nonzero `irq_level`, `ack_vector` is the vector base plus the winner's index and `ack_spurious` is 0.
- R7: If the acknowledged level does not match, or no request is active, the answer has `ack_spurious` 1, `ack_vector` 0 and `ack_external` 0.
- R8: Bit 6 of the abort source's control byte (index 2) reads the live level of `src_in[2]`.
- R9: For the printer source (index 7), writing bit 5 as 1 also clears pending. Bit 5 always reads 0.
- R10: Bit 4 of the serial source's control byte (index 3) is stored and read back. When it is 0 and serial wins an acknowledge, the answer has `ack_external` 1, `ack_vector` 0 and `ack_spurious` 0. When it is 1, the normal vector is returned.
- R11: In the general control register only bit 4 is stored; the other bits read 0. Addresses 14 and 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0-11 control bytes, 12 vector base, 13 general control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| src_in | input | 12 | Raw source inputs, bit n is source n |
| irq_level | output | 3 | Level of the current winning request, 0 for none |
| iack_req | input | 1 | Acknowledge request strobe |
| iack_level | input | 3 | Level being acknowledged |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_vector | output | 8 | Returned vector |
| ack_spurious | output | 1 | No source matches the acknowledged level |
| ack_external | output | 1 | The serial device supplies the vector |

## Verification
A source edge is taken by the pending register at the clock edge where it is first seen. From then on `irq_level` and the read data follow combinationally, so both are due one clock after the edge is driven. An acknowledge answer is registered and is due at the first clock edge after `iack_req` is presented, and it is gone one clock later. The bench drives every input on the falling edge and samples on the next falling edge, so each result is read half a cycle after the single register stage that produces it. The priority cases run from a table of source pairs with expected level and vector. Directed tests then cover edge latching, set-over-clear, global gating and the per-source special bits.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int unsigned CTRL_W   = 8;
   // control byte field positions
   localparam int unsigned F_EN     = 3;
   localparam int unsigned F_VSEL   = 4;
   localparam int unsigned F_ALTACK = 5;
   localparam int unsigned F_LIVE   = 6;
   localparam int unsigned F_PEND   = 7;
   // general control register
   localparam int unsigned G_IEN    = 4;
endpackage

// File: rtl/irqv_slot.sv
module irqv_slot
   import irqv_pkg::*;
#(
   parameter int unsigned LVL_W      = 3,
   parameter bit          IS_SW      = 1'b0,
   parameter bit          HAS_LIVE   = 1'b0,
   parameter bit          HAS_ALTACK = 1'b0,
   parameter bit          HAS_VSEL   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              src,
   output logic [CTRL_W-1:0] rdata,
   output logic              pend,
   output logic              en,
   output logic [LVL_W-1:0]  lvl,
   output logic              vsel
);
   logic             pend_q;
   logic             en_q;
   logic [LVL_W-1:0] lvl_q;
   logic             unused_bits;

   assign unused_bits = ^{wdata[F_LIVE], wdata[F_ALTACK], wdata[F_VSEL], src};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         lvl_q <= '0;
      end else if (wr) begin
         en_q  <= wdata[F_EN];
         lvl_q <= wdata[LVL_W-1:0];
      end
   end

   generate
      if (IS_SW) begin : g_sw
         always_ff @(posedge clk) begin
            if (!rst_n)  pend_q <= 1'b0;
            else if (wr) pend_q <= wdata[F_PEND];
         end
      end else begin : g_hw
         logic src_q;
         logic rise;
         logic clr;
         always_ff @(posedge clk) begin
            if (!rst_n) src_q <= 1'b0;
            else        src_q <= src;
         end
         assign rise = src & ~src_q;
         assign clr  = wr & (wdata[F_PEND] | (HAS_ALTACK & wdata[F_ALTACK]));
         always_ff @(posedge clk) begin
            if (!rst_n)    pend_q <= 1'b0;
            else if (rise) pend_q <= 1'b1;
            else if (clr)  pend_q <= 1'b0;
         end
      end

      if (HAS_VSEL) begin : g_vsel
         logic vsel_q;
         always_ff @(posedge clk) begin
            if (!rst_n)  vsel_q <= 1'b0;
            else if (wr) vsel_q <= wdata[F_VSEL];
         end
         assign vsel = vsel_q;
      end else begin : g_novsel
         assign vsel = 1'b0;
      end
   endgenerate

   always_comb begin
      rdata              = '0;
      rdata[LVL_W-1:0]   = lvl_q;
      rdata[F_EN]        = en_q;
      rdata[F_PEND]      = pend_q;
      if (HAS_LIVE) rdata[F_LIVE] = src;
      if (HAS_VSEL) rdata[F_VSEL] = vsel;
   end

   assign pend = pend_q;
   assign en   = en_q;
   assign lvl  = lvl_q;
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
   parameter int unsigned NUM_SRC = 12,
   parameter int unsigned LVL_W   = 3,
   localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]            req,
   input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
   output logic                          win_valid,
   output logic [LVL_W-1:0]              win_lvl,
   output logic [IDX_W-1:0]              win_idx
);
   // strict greater-than keeps the lowest index on a tie
   always_comb begin
      win_valid = 1'b0;
      win_lvl   = '0;
      win_idx   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req[i] && (!win_valid || lvl[i] > win_lvl)) begin
            win_valid = 1'b1;
            win_lvl   = lvl[i];
            win_idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irqv_ack.sv
module irqv_ack #(
   parameter int unsigned LVL_W = 3,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iack_req,
   input  logic [LVL_W-1:0] iack_level,
   input  logic             active,
   input  logic [LVL_W-1:0] win_lvl,
   input  logic [IDX_W-1:0] win_idx,
   input  logic             win_ext,
   input  logic [VEC_W-1:0] base,
   output logic             ack_valid,
   output logic [VEC_W-1:0] ack_vector,
   output logic             ack_spurious,
   output logic             ack_external
);
   logic match;
   assign match = active && (win_lvl == iack_level);

   always_ff @(posedge clk) begin
      if (!rst_n || !iack_req) begin
         ack_valid    <= 1'b0;
         ack_vector   <= '0;
         ack_spurious <= 1'b0;
         ack_external <= 1'b0;
      end else begin
         ack_valid    <= 1'b1;
         ack_spurious <= !match;
         ack_external <= match && win_ext;
         ack_vector   <= (match && !win_ext) ? base + VEC_W'(win_idx) : '0;
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqv_pkg::*;
#(
   parameter int unsigned    NUM_SRC     = 12,
   parameter int unsigned    LVL_W       = 3,
   parameter int unsigned    VEC_W       = 8,
   parameter int unsigned    ADDR_W      = 4,
   parameter logic [NUM_SRC-1:0] SW_MASK = 12'hC00,
   parameter int unsigned    ABORT_IDX   = 2,
   parameter int unsigned    SERIAL_IDX  = 3,
   parameter int unsigned    PRINTER_IDX = 7,
   parameter logic [VEC_W-1:0] BASE_RST  = 8'h40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [CTRL_W-1:0]  reg_wdata,
   output logic [CTRL_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   output logic [LVL_W-1:0]   irq_level,
   input  logic               iack_req,
   input  logic [LVL_W-1:0]   iack_level,
   output logic               ack_valid,
   output logic [VEC_W-1:0]   ack_vector,
   output logic               ack_spurious,
   output logic               ack_external
);
   localparam int unsigned IDX_W    = $clog2(NUM_SRC);
   localparam int unsigned ADR_BASE = NUM_SRC;
   localparam int unsigned ADR_GEN  = NUM_SRC + 1;

   // elaboration-time parameter checks
   if (LVL_W < 1 || LVL_W > F_EN) begin : g_bad_lvl
      $error("LVL_W must fit below the enable bit");
   end
   if (VEC_W < IDX_W || VEC_W > CTRL_W) begin : g_bad_vec
      $error("VEC_W must hold an index and fit a register byte");
   end
   if (ADR_GEN >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (ABORT_IDX >= NUM_SRC || SERIAL_IDX >= NUM_SRC || PRINTER_IDX >= NUM_SRC) begin : g_bad_idx
      $error("special source index out of range");
   end

   logic [NUM_SRC-1:0]              pend_vec;
   logic [NUM_SRC-1:0]              en_vec;
   logic [NUM_SRC-1:0]              vsel_vec;
   logic [NUM_SRC-1:0]              req_vec;
   logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_vec;
   logic [NUM_SRC-1:0][CTRL_W-1:0]  slot_rd;
   logic [VEC_W-1:0]                base_q;
   logic                            gen_en;
   logic                            win_valid;
   logic [LVL_W-1:0]                win_lvl;
   logic [IDX_W-1:0]                win_idx;
   logic                            win_ext;
   logic                            active;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
      irqv_slot #(
         .LVL_W      (LVL_W),
         .IS_SW      (SW_MASK[i]),
         .HAS_LIVE   (i == ABORT_IDX),
         .HAS_ALTACK (i == PRINTER_IDX),
         .HAS_VSEL   (i == SERIAL_IDX)
      ) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (reg_we && reg_addr == ADDR_W'(i)),
         .wdata (reg_wdata),
         .src   (src_in[i]),
         .rdata (slot_rd[i]),
         .pend  (pend_vec[i]),
         .en    (en_vec[i]),
         .lvl   (lvl_vec[i]),
         .vsel  (vsel_vec[i])
      );
      assign req_vec[i] = pend_vec[i] && en_vec[i] && (lvl_vec[i] != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= BASE_RST;
         gen_en <= 1'b0;
      end else if (reg_we) begin
         if (reg_addr == ADDR_W'(ADR_BASE)) base_q <= reg_wdata[VEC_W-1:0];
         if (reg_addr == ADDR_W'(ADR_GEN))  gen_en <= reg_wdata[G_IEN];
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (reg_addr == ADDR_W'(i)) reg_rdata = slot_rd[i];
      if (reg_addr == ADDR_W'(ADR_BASE)) reg_rdata = CTRL_W'(base_q);
      if (reg_addr == ADDR_W'(ADR_GEN))  reg_rdata[G_IEN] = gen_en;
   end

   irqv_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
      .req       (req_vec),
      .lvl       (lvl_vec),
      .win_valid (win_valid),
      .win_lvl   (win_lvl),
      .win_idx   (win_idx)
   );

   assign active    = gen_en && win_valid;
   assign irq_level = active ? win_lvl : '0;
   assign win_ext   = (win_idx == IDX_W'(SERIAL_IDX)) && !vsel_vec[win_idx];

   irqv_ack #(.LVL_W(LVL_W), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_ack (
      .clk          (clk),
      .rst_n        (rst_n),
      .iack_req     (iack_req),
      .iack_level   (iack_level),
      .active       (active),
      .win_lvl      (win_lvl),
      .win_idx      (win_idx),
      .win_ext      (win_ext),
      .base         (base_q),
      .ack_valid    (ack_valid),
      .ack_vector   (ack_vector),
      .ack_spurious (ack_spurious),
      .ack_external (ack_external)
   );
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
   parameter int unsigned NUM_SRC = 12,
   parameter int unsigned LVL_W   = 3,
   parameter int unsigned VEC_W   = 8,
   parameter logic [NUM_SRC-1:0] SW_MASK = 12'hC00
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [NUM_SRC-1:0] src_in,
   input logic [NUM_SRC-1:0] pend_vec,
   input logic               gen_en,
   input logic [LVL_W-1:0]   irq_level,
   input logic               iack_req,
   input logic               ack_valid,
   input logic [VEC_W-1:0]   ack_vector,
   input logic               ack_spurious,
   input logic               ack_external
);
   p_edge_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_in[0] && !$past(src_in[0])) |=> pend_vec[0]);

   p_sw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> ((pend_vec & SW_MASK) == ($past(pend_vec) & SW_MASK)));

   p_global_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |-> (irq_level == '0));

   p_level_needs_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level != '0) |-> (|pend_vec));

   p_ack_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      iack_req |=> ack_valid);

   p_ack_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !iack_req |=> !ack_valid);

   p_spur_no_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_spurious |-> (ack_valid && ack_vector == '0 && !ack_external));

   p_ext_no_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ack_external |-> (ack_valid && ack_vector == '0));
endmodule

bind irq_vector_ctrl irqv_chk #(
   .NUM_SRC (NUM_SRC),
   .LVL_W   (LVL_W),
   .VEC_W   (VEC_W),
   .SW_MASK (SW_MASK)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_we       (reg_we),
   .src_in       (src_in),
   .pend_vec     (pend_vec),
   .gen_en       (gen_en),
   .irq_level    (irq_level),
   .iack_req     (iack_req),
   .ack_valid    (ack_valid),
   .ack_vector   (ack_vector),
   .ack_spurious (ack_spurious),
   .ack_external (ack_external)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [11:0] src_in = '0;
   logic [2:0]  irq_level;
   logic        iack_req = 1'b0;
   logic [2:0]  iack_level = '0;
   logic        ack_valid;
   logic [7:0]  ack_vector;
   logic        ack_spurious;
   logic        ack_external;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   irq_vector_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
      .irq_level(irq_level), .iack_req(iack_req), .iack_level(iack_level),
      .ack_valid(ack_valid), .ack_vector(ack_vector),
      .ack_spurious(ack_spurious), .ack_external(ack_external)
   );

   typedef struct packed {
      logic [3:0] a;  logic [2:0] la;
      logic [3:0] b;  logic [2:0] lb;
      logic [2:0] xl; logic [7:0] xv;
   } vec_t;

   // pairs of hardware sources, expected level and vector (base 0x40)
   localparam vec_t TBL [6] = '{
      '{4'd0, 3'd2, 4'd5, 3'd6, 3'd6, 8'h45},
      '{4'd1, 3'd4, 4'd8, 3'd4, 3'd4, 8'h41},
      '{4'd9, 3'd7, 4'd2, 3'd1, 3'd7, 8'h49},
      '{4'd6, 3'd3, 4'd4, 3'd3, 3'd3, 8'h44},
      '{4'd7, 3'd5, 4'd0, 3'd0, 3'd5, 8'h47},
      '{4'd8, 3'd1, 4'd9, 3'd2, 3'd2, 8'h49}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input logic [11:0] m);
      @(negedge clk);
      src_in = src_in | m;
      @(negedge clk);
      src_in = src_in & ~m;
   endtask

   task automatic iack(input logic [2:0] l);
      @(negedge clk);
      iack_req = 1'b1; iack_level = l;
      @(negedge clk);
      iack_req = 1'b0;
   endtask

   task automatic clear_all();
      for (int i = 0; i < 12; i++) wr(4'(i), (i >= 10) ? 8'h00 : 8'h80);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 irq_level", irq_level, 0);
      chk("R1 ack_valid", ack_valid, 0);
      rd(4'd12, d); chk("R1 base", d, 8'h40);
      rd(4'd13, d); chk("R1 gen", d, 0);
      rd(4'd5, d);  chk("R1 ctrl5", d, 0);

      // R11 general control keeps only bit 4
      wr(4'd13, 8'hFF);
      rd(4'd13, d); chk("R11 gen readback", d, 8'h10);

      // table: R4 R5 R6
      foreach (TBL[k]) begin
         clear_all();
         wr(TBL[k].a, {5'b00001, TBL[k].la});
         wr(TBL[k].b, {5'b00001, TBL[k].lb});
         pulse((12'd1 << TBL[k].a) | (12'd1 << TBL[k].b));
         chk("R4/R5 table level", irq_level, TBL[k].xl);
         iack(TBL[k].xl);
         chk("R6 table ack_valid", ack_valid, 1);
         chk("R6 table vector", ack_vector, TBL[k].xv);
         chk("R6 table spurious", ack_spurious, 0);
      end

      // R2 edge latch, disabled latch, held high, set wins
      clear_all();
      wr(4'd0, 8'h00);
      pulse(12'h001);
      rd(4'd0, d); chk("R2 latch while disabled", d, 8'h80);
      @(negedge clk); src_in[1] = 1'b1;
      @(negedge clk);
      wr(4'd1, 8'h80);
      repeat (2) @(negedge clk);
      rd(4'd1, d); chk("R2 held high no relatch", d, 8'h00);
      src_in[1] = 1'b0;
      @(negedge clk);
      src_in[4] = 1'b1; reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 8'h80;
      @(negedge clk);
      reg_we = 1'b0; src_in[4] = 1'b0;
      rd(4'd4, d); chk("R2 set beats clear", d, 8'h80);

      // R3 software source
      pulse(12'h400);
      rd(4'd10, d); chk("R3 input ignored", d, 8'h00);
      wr(4'd10, 8'h8B);
      rd(4'd10, d); chk("R3 written pending", d, 8'h8B);
      chk("R3 level", irq_level, 3);
      iack(3'd3);
      chk("R3 vector", ack_vector, 8'h4A);
      @(negedge clk);
      chk("R6 one-shot", ack_valid, 0);
      wr(4'd10, 8'h0B);
      chk("R3 cleared level", irq_level, 0);

      // R7 spurious
      iack(3'd5);
      chk("R7 no request spurious", ack_spurious, 1);
      chk("R7 no request vector", ack_vector, 0);
      wr(4'd11, 8'h8A);
      iack(3'd4);
      chk("R7 mismatch spurious", ack_spurious, 1);

      // R4 global gate
      chk("R4 level before gate", irq_level, 2);
      wr(4'd13, 8'h00);
      chk("R4 gated level", irq_level, 0);
      iack(3'd2);
      chk("R4 gated ack spurious", ack_spurious, 1);
      wr(4'd13, 8'h10);
      chk("R4 ungated level", irq_level, 2);
      wr(4'd11, 8'h0A);

      // R8 abort live bit
      @(negedge clk); src_in[2] = 1'b1;
      rd(4'd2, d); chk("R8 live high", d, 8'hC0);
      src_in[2] = 1'b0;
      rd(4'd2, d); chk("R8 live low", d, 8'h80);
      wr(4'd2, 8'h80);

      // R9 printer alternate clear
      pulse(12'h080);
      wr(4'd7, 8'h20);
      rd(4'd7, d); chk("R9 bit5 clears", d, 8'h00);
      pulse(12'h080);
      wr(4'd7, 8'h0D);
      rd(4'd7, d); chk("R9 no clear", d, 8'h8D);
      wr(4'd7, 8'h80);

      // R10 serial vector select
      clear_all();
      wr(4'd3, 8'h0E);
      pulse(12'h008);
      chk("R10 level", irq_level, 6);
      iack(3'd6);
      chk("R10 external", ack_external, 1);
      chk("R10 external vector", ack_vector, 0);
      chk("R10 external not spurious", ack_spurious, 0);
      wr(4'd3, 8'h1E);
      rd(4'd3, d); chk("R10 readback", d, 8'h9E);
      iack(3'd6);
      chk("R10 internal vector", ack_vector, 8'h43);
      chk("R10 internal flag", ack_external, 0);

      // R11 unused addresses
      wr(4'd14, 8'h55);
      rd(4'd14, d); chk("R11 addr14", d, 0);
      rd(4'd12, d); chk("R11 base untouched", d, 8'h40);
      wr(4'd12, 8'h80);
      rd(4'd12, d); chk("R11 base write", d, 8'h80);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule